// File: doc/BRIEF.md
# AC-link output frame serializer

This block is the controller-side transmitter of an AC-link style serial audio link. It runs on the bit clock supplied by the codec. Once per 256-bit frame it captures a parallel set of slot contents: a 16-bit tag word, a command address (read/write flag plus register index), 16 bits of command data, and left and right PCM samples. It then sends them MSB first on a single serial line, together with a frame sync strobe.

Every data slot has its own valid flag. A slot whose flag is clear is sent as all zeros, and the eight trailing slots that carry no content are always zero. A mono select copies the left sample into the right slot as well, so both stereo slots carry the same value. Sync and data change on the rising edge of the bit clock, which leaves each bit stable half a period before the receiver samples it on the falling edge.

A one-cycle `frameDone` pulse marks the last bit of every frame. The slot inputs are captured on the next rising edge, so the source presents the next set of values while `frameDone` is high.

Top module: `acl_frame_tx`

## Requirements
- R1: While `rstN` is low, `syncOut`, `sdataOut` and `frameDone` are all 0.
- R2: A frame lasts exactly 256 bit clocks. `syncOut` is high for 16 consecutive bit periods, beginning one period before the first data bit of the frame (the last bit period of the previous frame). It is low for the other 240 periods.
- R3: Serial bits change only on rising edges of `bitClk`. Every slot is sent most significant bit first, one bit per clock.
- R4: Frame bits 0..15 carry `tagIn`, bit 15 first, whatever the valid flags are.
- R5: Slot 1 (frame bits 16..35), when `slotValid[0]` is 1, carries `cmdRead` in its bit 19 (1 = read, 0 = write), `cmdIndex` in bits 18:12, and zeros in bits 11:0.
- R6: Slot 2 (frame bits 36..55), when `slotValid[1]` is 1, carries `cmdData` in its bits 19:4 and zeros in bits 3:0.
- R7: Slot 3 (bits 56..75) carries `pcmLeft` when `slotValid[2]` is 1. Slot 4 (bits 76..95) carries `pcmRight` when `slotValid[3]` is 1 and `monoSel` is 0.
- R8: A slot whose valid flag is 0 is sent as 20 zero bits. Slots 5..12 (frame bits 96..255) are always zero.
- R9: With `monoSel` = 1, slot 4, when valid, carries `pcmLeft`, the same value as slot 3.
- R10: `frameDone` is a one-cycle pulse, high during the last bit period of each frame. All slot inputs are captured on the rising edge that ends that pulse, and changes to them at any other time have no effect on the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock from the codec |
| rstN | input | 1 | Asynchronous active-low reset |
| tagIn | input | 16 | Tag slot word |
| cmdRead | input | 1 | Command direction, 1 = read |
| cmdIndex | input | 7 | Control register index |
| cmdData | input | 16 | Command write data |
| pcmLeft | input | 20 | Left PCM sample |
| pcmRight | input | 20 | Right PCM sample |
| monoSel | input | 1 | Copy left sample into both PCM slots |
| slotValid | input | 4 | Valid flags for slots 1..4 (bit 0 = slot 1) |
| syncOut | output | 1 | Frame sync strobe |
| sdataOut | output | 1 | Serial data, MSB first |
| frameDone | output | 1 | Last-bit pulse; inputs captured next edge |

## Verification
The bench deserializes the stream on falling edges, the way a receiver would. A design that raised sync in step with the first tag bit, instead of one period earlier, shifts every slot by one bit, and all slot comparisons then fail. Frames with mixed valid flags and inverted "don't care" inputs catch a design that forgets to zero a masked slot, pads slot 1 or slot 2 with stray bits, or leaks the right sample in mono mode. One frame inverts every input shortly after capture, which exposes a design that reads the inputs live instead of holding the captured values.

// File: rtl/acl_tx_pkg.sv
package acl_tx_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int NUM_DATA   = 4;
  localparam int IDX_W      = 7;
  localparam int CMD_W      = 16;
  localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int SEL_W      = $clog2(NUM_SLOTS + 1);
  localparam int BIT_W      = $clog2(SLOT_W);

  typedef struct packed {
    logic             loadFrame;
    logic             slotStart;
    logic [SEL_W-1:0] slotSel;
    logic             syncNext;
    logic             lastBit;
  } ctrlStrobes_t;
endpackage

// File: rtl/acl_tx_ctrl.sv
module acl_tx_ctrl
  import acl_tx_pkg::*;
(
  input  logic         bitClk,
  input  logic         rstN,
  output ctrlStrobes_t strobes
);
  logic [SEL_W-1:0] slotIdx;
  logic [BIT_W-1:0] bitIdx;
  logic [BIT_W-1:0] slotLast;

  // slot 0 is the short tag slot
  assign slotLast = (slotIdx == '0) ? BIT_W'(TAG_W - 1) : BIT_W'(SLOT_W - 1);

  // counters name the bit that the next rising edge launches;
  // reset points at the final bit so sync leads the first frame
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      slotIdx <= SEL_W'(NUM_SLOTS);
      bitIdx  <= BIT_W'(SLOT_W - 1);
    end else if (bitIdx == slotLast) begin
      bitIdx  <= '0;
      slotIdx <= (slotIdx == SEL_W'(NUM_SLOTS)) ? '0 : slotIdx + 1'b1;
    end else begin
      bitIdx <= bitIdx + 1'b1;
    end
  end

  always_comb begin
    strobes.slotSel   = slotIdx;
    strobes.slotStart = (bitIdx == '0);
    strobes.loadFrame = (slotIdx == '0) && (bitIdx == '0);
    strobes.lastBit   = (slotIdx == SEL_W'(NUM_SLOTS)) && (bitIdx == BIT_W'(SLOT_W - 1));
    strobes.syncNext  = strobes.lastBit ||
                        ((slotIdx == '0) && (bitIdx < BIT_W'(TAG_W - 1)));
  end
endmodule

// File: rtl/acl_tx_dp.sv
module acl_tx_dp
  import acl_tx_pkg::*;
(
  input  logic                bitClk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [TAG_W-1:0]    tagIn,
  input  logic                cmdRead,
  input  logic [IDX_W-1:0]    cmdIndex,
  input  logic [CMD_W-1:0]    cmdData,
  input  logic [SLOT_W-1:0]   pcmLeft,
  input  logic [SLOT_W-1:0]   pcmRight,
  input  logic                monoSel,
  input  logic [NUM_DATA-1:0] slotValid,
  output logic                syncOut,
  output logic                sdataOut,
  output logic                frameDone
);
  logic [SLOT_W-1:0] rawSlot  [NUM_DATA];
  logic [SLOT_W-1:0] maskSlot [NUM_DATA];
  logic [SLOT_W-1:0] heldSlot [NUM_DATA];
  logic [SLOT_W-1:0] srcWord;
  logic [SLOT_W-1:0] shiftReg;

  always_comb begin
    rawSlot[0] = {cmdRead, cmdIndex, {(SLOT_W - 1 - IDX_W){1'b0}}};
    rawSlot[1] = {cmdData, {(SLOT_W - CMD_W){1'b0}}};
    rawSlot[2] = pcmLeft;
    rawSlot[3] = monoSel ? pcmLeft : pcmRight;
  end

  for (genvar i = 0; i < NUM_DATA; i++) begin : g_slot
    assign maskSlot[i] = slotValid[i] ? rawSlot[i] : '0;

    always_ff @(posedge bitClk or negedge rstN) begin
      if (!rstN)                  heldSlot[i] <= '0;
      else if (strobes.loadFrame) heldSlot[i] <= maskSlot[i];
    end
  end

  // the tag goes out on the capture edge itself, so it comes straight from the input
  always_comb begin
    srcWord = '0;
    if (strobes.slotSel == '0) srcWord = {tagIn, {(SLOT_W - TAG_W){1'b0}}};
    for (int k = 0; k < NUM_DATA; k++)
      if (strobes.slotSel == SEL_W'(k + 1)) srcWord = heldSlot[k];
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      sdataOut  <= 1'b0;
      syncOut   <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      if (strobes.slotStart) begin
        sdataOut <= srcWord[SLOT_W-1];
        shiftReg <= {srcWord[SLOT_W-2:0], 1'b0};
      end else begin
        sdataOut <= shiftReg[SLOT_W-1];
        shiftReg <= {shiftReg[SLOT_W-2:0], 1'b0};
      end
      syncOut   <= strobes.syncNext;
      frameDone <= strobes.lastBit;
    end
  end
endmodule

// File: rtl/acl_frame_tx.sv
module acl_frame_tx
  import acl_tx_pkg::*;
(
  input  logic                bitClk,
  input  logic                rstN,
  input  logic [TAG_W-1:0]    tagIn,
  input  logic                cmdRead,
  input  logic [IDX_W-1:0]    cmdIndex,
  input  logic [CMD_W-1:0]    cmdData,
  input  logic [SLOT_W-1:0]   pcmLeft,
  input  logic [SLOT_W-1:0]   pcmRight,
  input  logic                monoSel,
  input  logic [NUM_DATA-1:0] slotValid,
  output logic                syncOut,
  output logic                sdataOut,
  output logic                frameDone
);
  ctrlStrobes_t strobes;

  acl_tx_ctrl ctrl_i (
    .bitClk (bitClk),
    .rstN   (rstN),
    .strobes(strobes)
  );

  acl_tx_dp dp_i (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .strobes  (strobes),
    .tagIn    (tagIn),
    .cmdRead  (cmdRead),
    .cmdIndex (cmdIndex),
    .cmdData  (cmdData),
    .pcmLeft  (pcmLeft),
    .pcmRight (pcmRight),
    .monoSel  (monoSel),
    .slotValid(slotValid),
    .syncOut  (syncOut),
    .sdataOut (sdataOut),
    .frameDone(frameDone)
  );
endmodule

// File: rtl/acl_frame_tx_chk.sv
module acl_frame_tx_chk
  import acl_tx_pkg::*;
(
  input logic bitClk,
  input logic rstN,
  input logic syncOut,
  input logic sdataOut,
  input logic frameDone
);
  logic [POS_W-1:0] posCnt;
  logic             seen;

  // independent frame position, restarted by each end-of-frame pulse
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      posCnt <= '0;
      seen   <= 1'b0;
    end else begin
      posCnt <= frameDone ? '0 : posCnt + 1'b1;
      if (frameDone) seen <= 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge bitClk) disable iff (!rstN)
    frameDone |=> !frameDone); // R10
  AST_FRAME_PERIOD: assert property (@(posedge bitClk) disable iff (!rstN)
    (seen && frameDone) |-> (posCnt == POS_W'(FRAME_BITS - 1))); // R2
  AST_SYNC_AT_DONE: assert property (@(posedge bitClk) disable iff (!rstN)
    frameDone |-> syncOut); // R2
  AST_SYNC_RISE: assert property (@(posedge bitClk) disable iff (!rstN)
    $rose(syncOut) |-> frameDone); // R2
  AST_SYNC_HIGH_TAG: assert property (@(posedge bitClk) disable iff (!rstN)
    (seen && !frameDone && posCnt < POS_W'(TAG_W - 1)) |-> syncOut); // R2
  AST_SYNC_LOW_REST: assert property (@(posedge bitClk) disable iff (!rstN)
    (seen && !frameDone && posCnt >= POS_W'(TAG_W - 1)) |-> !syncOut); // R2
  AST_CMD_ADDR_PAD: assert property (@(posedge bitClk) disable iff (!rstN)
    (seen && posCnt >= POS_W'(TAG_W + 1 + IDX_W) && posCnt < POS_W'(TAG_W + SLOT_W))
      |-> !sdataOut); // R5
  AST_CMD_DATA_PAD: assert property (@(posedge bitClk) disable iff (!rstN)
    (seen && posCnt >= POS_W'(TAG_W + SLOT_W + CMD_W) && posCnt < POS_W'(TAG_W + 2 * SLOT_W))
      |-> !sdataOut); // R6
  AST_TAIL_ZERO: assert property (@(posedge bitClk) disable iff (!rstN)
    (seen && posCnt >= POS_W'(TAG_W + NUM_DATA * SLOT_W)) |-> !sdataOut); // R8
endmodule

bind acl_frame_tx acl_frame_tx_chk chk_i (
  .bitClk   (bitClk),
  .rstN     (rstN),
  .syncOut  (syncOut),
  .sdataOut (sdataOut),
  .frameDone(frameDone)
);

// File: tb/acl_frame_tx_tb_top.sv
`timescale 1ns/1ps
module acl_frame_tx_tb_top;
  logic        bitClk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] tagIn = '0;
  logic        cmdRead = 1'b0;
  logic [6:0]  cmdIndex = '0;
  logic [15:0] cmdData = '0;
  logic [19:0] pcmLeft = '0;
  logic [19:0] pcmRight = '0;
  logic        monoSel = 1'b0;
  logic [3:0]  slotValid = '0;
  logic        syncOut, sdataOut, frameDone;

  int checks = 0;
  int errors = 0;
  int framesChecked = 0;
  bit finished = 1'b0;
  localparam int NUM_FRAMES = 7;

  logic [255:0] expQ[$];

  always #2 bitClk = ~bitClk;

  acl_frame_tx dut_i (
    .bitClk(bitClk), .rstN(rstN), .tagIn(tagIn), .cmdRead(cmdRead),
    .cmdIndex(cmdIndex), .cmdData(cmdData), .pcmLeft(pcmLeft),
    .pcmRight(pcmRight), .monoSel(monoSel), .slotValid(slotValid),
    .syncOut(syncOut), .sdataOut(sdataOut), .frameDone(frameDone)
  );

  task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // expected frame, frame bit p at vector index 255-p
  function automatic logic [255:0] mkFrame(
      input logic [15:0] tg, input logic rd, input logic [6:0] idx,
      input logic [15:0] dat, input logic [19:0] l, input logic [19:0] r,
      input logic mono, input logic [3:0] vld);
    logic [19:0] s1, s2, s3, s4;
    s1 = vld[0] ? {rd, idx, 12'h000} : 20'h0;
    s2 = vld[1] ? {dat, 4'h0} : 20'h0;
    s3 = vld[2] ? l : 20'h0;
    s4 = vld[3] ? (mono ? l : r) : 20'h0;
    return {tg, s1, s2, s3, s4, 160'h0};
  endfunction

  task automatic sendFrame(
      input logic [15:0] tg, input logic rd, input logic [6:0] idx,
      input logic [15:0] dat, input logic [19:0] l, input logic [19:0] r,
      input logic mono, input logic [3:0] vld, input bit scramble);
    do @(negedge bitClk); while (!frameDone);
    expQ.push_back(mkFrame(tg, rd, idx, dat, l, r, mono, vld));
    tagIn = tg; cmdRead = rd; cmdIndex = idx; cmdData = dat;
    pcmLeft = l; pcmRight = r; monoSel = mono; slotValid = vld;
    if (scramble) begin
      // R10: inputs changed after capture must not reach the frame
      repeat (3) @(negedge bitClk);
      tagIn = ~tg; cmdRead = ~rd; cmdIndex = ~idx; cmdData = ~dat;
      pcmLeft = ~l; pcmRight = ~r; monoSel = ~mono; slotValid = ~vld;
    end
  endtask

  // monitor: receiver-style capture on falling edges
  initial begin
    logic [255:0] gotBits, syncBits, doneBits, expSync, expDone, exp;
    bit inFrame, prevSync;
    int cnt;
    inFrame = 1'b0; prevSync = 1'b0; cnt = 0;
    expSync = '0; expDone = '0;
    for (int p = 0; p < 15; p++) expSync[255 - p] = 1'b1;
    expSync[0] = 1'b1;
    expDone[0] = 1'b1;
    gotBits = '0; syncBits = '0; doneBits = '0;
    forever begin
      @(negedge bitClk);
      if (!inFrame) begin
        if (rstN && syncOut && !prevSync) begin
          inFrame = 1'b1;
          cnt = 0;
        end
        prevSync = syncOut;
      end else begin
        gotBits[255 - cnt]  = sdataOut;
        syncBits[255 - cnt] = syncOut;
        doneBits[255 - cnt] = frameDone;
        cnt++;
        if (cnt == 256) begin
          cnt = 0;
          if (expQ.size() > 0) begin
            exp = expQ.pop_front();
            chk("R2 sync shape", syncBits, expSync);
            chk("R10 done pulse", doneBits, expDone);
            chk("R4 tag slot", {240'h0, gotBits[255:240]}, {240'h0, exp[255:240]});
            chk("R5 cmd addr slot", {236'h0, gotBits[239:220]}, {236'h0, exp[239:220]});
            chk("R6 cmd data slot", {236'h0, gotBits[219:200]}, {236'h0, exp[219:200]});
            chk("R7 R9 left slot", {236'h0, gotBits[199:180]}, {236'h0, exp[199:180]});
            chk("R7 R9 right slot", {236'h0, gotBits[179:160]}, {236'h0, exp[179:160]});
            chk("R8 tail slots", {96'h0, gotBits[159:0]}, {96'h0, exp[159:0]});
            chk("R3 whole frame order", gotBits, exp);
            framesChecked++;
          end
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge bitClk);
    chk("R1 reset sync", {255'h0, syncOut}, 256'h0);
    chk("R1 reset data", {255'h0, sdataOut}, 256'h0);
    chk("R1 reset done", {255'h0, frameDone}, 256'h0);
    rstN = 1'b1;
    // stereo, all slots valid, read command
    sendFrame(16'hF800, 1'b1, 7'h26, 16'hA5C3, 20'h81234, 20'h7FEDC, 1'b0, 4'hF, 1'b0);
    // R8: only command slots valid, PCM inputs must be masked
    sendFrame(16'hE000, 1'b0, 7'h02, 16'h1357, 20'hFFFFF, 20'hFFFFF, 1'b0, 4'h3, 1'b0);
    // R9: mono with both PCM slots valid
    sendFrame(16'h9800, 1'b0, 7'h7F, 16'hFFFF, 20'hC0F0A, 20'h12345, 1'b1, 4'hC, 1'b0);
    // R8: nothing valid, every input all ones
    sendFrame(16'h0001, 1'b1, 7'h7F, 16'hFFFF, 20'hFFFFF, 20'hFFFFF, 1'b1, 4'h0, 1'b0);
    // R9 with R8: mono, only left valid
    sendFrame(16'h9000, 1'b0, 7'h11, 16'h0F0F, 20'h3C3C3, 20'hFFFFF, 1'b1, 4'h4, 1'b0);
    // R10: inputs inverted right after capture
    sendFrame(16'hF801, 1'b1, 7'h7F, 16'h8001, 20'h80001, 20'h00001, 1'b0, 4'hF, 1'b1);
    // R3: alternating bit patterns
    sendFrame(16'hAAAA, 1'b0, 7'h55, 16'h5555, 20'hAAAAA, 20'h55555, 1'b0, 4'hF, 1'b0);
    wait (framesChecked == NUM_FRAMES);
    repeat (2) @(negedge bitClk);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge bitClk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: frames checked %0d expected %0d", framesChecked, NUM_FRAMES);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule